// File: doc/BRIEF.md
# Ping-pong frame buffer burst address sequencer

This block turns a stream of 32-byte burst requests from an image capture front end into memory write addresses. It fills one frame buffer at a time and switches between two buffers. A rising edge on the frame-sync input starts each frame. On that edge the block flips the active buffer, loads the write address from that buffer's base, clears its burst count and enables transfers. Each request taken while transfers are enabled produces one write strobe at the current address. The address then moves forward by one burst of 32 bytes.

When the frame's burst count is reached, the block disables itself and reports the finished buffer for display. It stays disabled until the next frame-sync edge. Requests that arrive while it is disabled are acknowledged and discarded, and a saturating counter records them. A frame-sync edge that arrives before the count is reached abandons the partial frame and raises a short-frame pulse.

The controller has three states. `ST_IDLE` holds from reset until the first frame-sync rise. `ST_ARMED` accepts bursts. `ST_DONE` is entered when the last burst of a frame is accepted. There are four transitions. A frame-sync rise moves the controller from `ST_IDLE` or `ST_DONE` to `ST_ARMED`. A frame-sync rise taken in `ST_ARMED` restarts `ST_ARMED` on the other buffer. Acceptance of the final burst moves the controller from `ST_ARMED` to `ST_DONE`.

Top module: `fbuf_burst_seq`

## Requirements
- R1: During and straight after reset, the controller is in `ST_IDLE` with `active_buf` = 1 and `done_buf` = 0. `frame_done`, `short_frame`, `wr_strobe` and `drop_count` are all 0.
- R2: A frame-sync rise is `vsync` = 1 at a clock edge after `vsync` = 0 at the edge before. On that edge `active_buf` inverts. The write address is loaded from the new buffer's base (`base_a` for index 0, `base_b` for index 1), the burst count is cleared, `burst_total` is captured and the controller enters `ST_ARMED`.
- R3: In `ST_ARMED`, a cycle with `burst_req` = 1 and no frame-sync rise asserts `wr_strobe` in that same cycle. The k-th write of a frame (k from 0) goes to the buffer base plus 32·k.
- R4: When the accepted burst is number `burst_total` of the frame, the controller enters `ST_DONE`. `frame_done` is then high for exactly the following cycle, and `done_buf` takes the index of the buffer just filled.
- R5: A request in `ST_IDLE`, in `ST_DONE`, or in a cycle that carries a frame-sync rise is acknowledged in that same cycle without `wr_strobe`. `drop_count` rises by one at that edge.
- R6: `drop_count` saturates at its all-ones value.
- R7: A frame-sync rise taken in `ST_ARMED` raises `short_frame` for exactly the following cycle and restarts on the other buffer as in R2.
- R8: Holding `vsync` high, or a falling edge of `vsync`, changes neither the buffer index nor the state.
- R9: `burst_ack` follows `burst_req` in every cycle, and `wr_strobe` is never high without `burst_ack`.
- R10: `wr_addr` bits [4:0] are always 0 while writing, even if a base address has any of those bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame-sync level, synchronous to clk |
| burst_req | input | 1 | A 32-byte burst is ready at the source |
| base_a | input | ADDR_W | Base address of buffer 0 |
| base_b | input | ADDR_W | Base address of buffer 1 |
| burst_total | input | CNT_W | Bursts per frame, at least 1 |
| wr_addr | output | ADDR_W | Destination address of the current burst |
| wr_strobe | output | 1 | A burst is written to wr_addr this cycle |
| burst_ack | output | 1 | The request is consumed this cycle |
| frame_done | output | 1 | One-cycle pulse after the last burst of a frame |
| active_buf | output | 1 | Index of the buffer being filled |
| done_buf | output | 1 | Index of the last fully written buffer |
| short_frame | output | 1 | One-cycle pulse after an aborted frame |
| drop_count | output | DROP_W | Saturating count of discarded requests |

## Verification
The assertions assume that `vsync` and `burst_req` are synchronous to the clock and that `burst_total` is at least one. They also assume that both base addresses and `burst_total` are stable when a frame-sync rise is taken. The bench changes inputs only on the falling clock edge and holds `burst_total` at 3 for the whole run. It loads the base addresses once during reset. One of those bases is deliberately misaligned so that the masking of the low address bits can be seen at the ports.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2
    } fbs_state_t;
endpackage

// File: rtl/fbs_edge_det.sv
module fbs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    // Reset high so a sync already asserted at reset release is not taken as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 11,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count
);
    localparam int OFS_W = $clog2(BURST_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (restart) begin
            addr_q <= {base[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            cnt_q  <= '0;
        end else if (advance) begin
            addr_q <= addr_q + STEP;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign addr  = addr_q;
    assign count = cnt_q;

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> addr == $past(addr) + STEP); // R3
endmodule

// File: rtl/fbs_drop_cnt.sv
module fbs_drop_cnt #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [DROP_W-1:0] value
);
    localparam logic [DROP_W-1:0] MAXV = {DROP_W{1'b1}};

    logic [DROP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (inc && cnt_q != MAXV)  cnt_q <= cnt_q + DROP_W'(1);
    end

    assign value = cnt_q;

    AST_DROP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (value == MAXV) |=> value == MAXV); // R6
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && value != MAXV) |=> value == $past(value) + DROP_W'(1)); // R5
endmodule

// File: rtl/fbuf_burst_seq.sv
module fbuf_burst_seq #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 11,
    parameter int DROP_W      = 16,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              burst_req,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [CNT_W-1:0]  burst_total,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_strobe,
    output logic              burst_ack,
    output logic              frame_done,
    output logic              active_buf,
    output logic              done_buf,
    output logic              short_frame,
    output logic [DROP_W-1:0] drop_count
);
    import fbs_pkg::*;

    localparam int OFS_W = $clog2(BURST_BYTES);

    fbs_state_t        state_q, state_d;
    logic              vsync_rise;
    logic              accept;
    logic              last_burst;
    logic              drop_evt;
    logic [CNT_W-1:0]  burst_cnt;
    logic [CNT_W-1:0]  total_q;
    logic [ADDR_W-1:0] next_base;
    logic              buf_q, done_buf_q, frame_done_q, short_q;

    fbs_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (vsync),
        .rise     (vsync_rise)
    );

    // The buffer about to become active is the inverse of the current one.
    assign next_base = buf_q ? base_a : base_b;

    fbs_addr_gen #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (vsync_rise),
        .advance (accept),
        .base    (next_base),
        .addr    (wr_addr),
        .count   (burst_cnt)
    );

    fbs_drop_cnt #(
        .DROP_W (DROP_W)
    ) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_evt),
        .value (drop_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (vsync_rise) state_d = ST_ARMED;
            ST_ARMED: begin
                if (vsync_rise)      state_d = ST_ARMED;
                else if (last_burst) state_d = ST_DONE;
            end
            ST_DONE:  if (vsync_rise) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output and event decode
    always_comb begin
        accept     = (state_q == ST_ARMED) && !vsync_rise && burst_req;
        last_burst = accept && (burst_cnt + CNT_W'(1) == total_q);
        drop_evt   = burst_req && !accept;
        wr_strobe  = accept;
        burst_ack  = burst_req;
    end

    // Frame bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q        <= 1'b1;
            done_buf_q   <= 1'b0;
            frame_done_q <= 1'b0;
            short_q      <= 1'b0;
            total_q      <= '0;
        end else begin
            frame_done_q <= last_burst;
            short_q      <= vsync_rise && (state_q == ST_ARMED);
            if (vsync_rise) begin
                buf_q   <= ~buf_q;
                total_q <= burst_total;
            end
            if (last_burst) done_buf_q <= buf_q;
        end
    end

    assign active_buf  = buf_q;
    assign done_buf    = done_buf_q;
    assign frame_done  = frame_done_q;
    assign short_frame = short_q;

    AST_BUF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_rise |=> active_buf != $past(active_buf)); // R2
    AST_NO_EDGE_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_rise |=> active_buf == $past(active_buf)); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> (!wr_strobe || wr_addr == $past(wr_addr) + ADDR_W'(BURST_BYTES))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R4
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !wr_strobe); // R4
    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        short_frame |=> !short_frame); // R7
    AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> burst_ack); // R9
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        burst_ack |-> burst_req); // R9
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> wr_addr[OFS_W-1:0] == '0); // R10
endmodule

// File: tb/fbuf_burst_seq_tb.sv
module fbuf_burst_seq_tb_top;
    localparam int AW = 32;
    localparam int CW = 11;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          vsync, burst_req;
    logic [AW-1:0] base_a, base_b;
    logic [CW-1:0] burst_total;
    logic [AW-1:0] wr_addr;
    logic          wr_strobe, burst_ack, frame_done, active_buf, done_buf, short_frame;
    logic [DW-1:0] drop_count;

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    fbuf_burst_seq #(.ADDR_W(AW), .CNT_W(CW), .DROP_W(DW), .BURST_BYTES(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .burst_req(burst_req),
        .base_a(base_a), .base_b(base_b), .burst_total(burst_total),
        .wr_addr(wr_addr), .wr_strobe(wr_strobe), .burst_ack(burst_ack),
        .frame_done(frame_done), .active_buf(active_buf), .done_buf(done_buf),
        .short_frame(short_frame), .drop_count(drop_count)
    );

    // {vsync, req, exp strobe, exp ack, exp buf, exp done, exp short, exp drop[3:0], exp addr[15:0]}
    localparam int NV = 14;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,4'd0,16'h0000}, // R5 drop in idle
        {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd1,16'h0000}, // R2 rise
        {1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h1000}, // R3 first write
        {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,16'h0000}, // R8 held high
        {1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h1020}, // R3
        {1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h1040}, // R4 last
        {1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd1,16'h0000}, // R4 done, R5 drop
        {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,16'h0000}, // R4 pulse ends
        {1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd2,16'h0000}, // R5 rise cycle drops
        {1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,4'd3,16'h2040}, // R10 masked base
        {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd3,16'h0000}, // R8 fall
        {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd3,16'h0000}, // R7 early rise
        {1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'd3,16'h1000}, // R7 short pulse
        {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,16'h0000}  // R7 pulse ends
    };

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic r);
        @(negedge clk);
        vsync = v;
        burst_req = r;
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; vsync = 1'b0; burst_req = 1'b0;
        base_a = 32'h0000_1000; base_b = 32'h0000_2047; burst_total = CW'(3);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 reset state
        chk(active_buf == 1'b1 && done_buf == 1'b0, "R1 buffers", {active_buf, done_buf}, 32'h2);
        chk(!frame_done && !short_frame && !wr_strobe && drop_count == 0, "R1 flags",
            {frame_done, short_frame, wr_strobe, drop_count}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [26:0] e;
            e = VEC[i];
            step(e[26], e[25]);
            chk(wr_strobe == e[24], $sformatf("R3 strobe step %0d", i), wr_strobe, e[24]);
            chk(burst_ack == e[23], $sformatf("R9 ack step %0d", i), burst_ack, e[23]);
            chk(active_buf == e[22], $sformatf("R2 buffer step %0d", i), active_buf, e[22]);
            chk(frame_done == e[21], $sformatf("R4 done step %0d", i), frame_done, e[21]);
            chk(short_frame == e[20], $sformatf("R7 short step %0d", i), short_frame, e[20]);
            chk(drop_count == e[19:16], $sformatf("R5 drops step %0d", i), drop_count, e[19:16]);
            if (e[24])
                chk(wr_addr == {16'h0, e[15:0]}, $sformatf("R3 addr step %0d", i), wr_addr, {16'h0, e[15:0]});
        end

        // Finish the restarted frame on buffer 0
        step(1'b1, 1'b1);
        chk(wr_strobe && wr_addr == 32'h1020, "R3 restart second", wr_addr, 32'h1020);
        step(1'b1, 1'b1);
        chk(wr_strobe && wr_addr == 32'h1040, "R3 restart third", wr_addr, 32'h1040);
        step(1'b0, 1'b0);
        chk(frame_done && done_buf == 1'b0, "R4 done buffer 0", {frame_done, done_buf}, 32'h2);

        // Next frame fills buffer 1
        step(1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1);
            chk(wr_strobe && active_buf && wr_addr == 32'h2040 + 32 * k, "R3 buffer 1 sequence",
                wr_addr, 32'h2040 + 32 * k);
        end
        step(1'b1, 1'b0);
        chk(frame_done && done_buf == 1'b1, "R4 done buffer 1", {frame_done, done_buf}, 32'h3);
        step(1'b1, 1'b0);
        chk(!frame_done, "R4 single pulse", frame_done, 0);

        // R8: falling edge and held level leave state alone
        step(1'b0, 1'b1);
        chk(!wr_strobe && burst_ack && active_buf, "R8 fall no effect", {wr_strobe, active_buf}, 32'h1);

        // R6: saturate drop counter
        for (int k = 0; k < 20; k++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(drop_count == 4'hF, "R6 saturation", drop_count, 32'hF);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(drop_count == 4'hF, "R6 held at max", drop_count, 32'hF);
        chk(!wr_strobe && !burst_ack, "R9 idle ack", {wr_strobe, burst_ack}, 0);

        finish_run();
    end
endmodule